// File: doc/BRIEF.md
# Level-Latched Interrupt Aggregator

This block merges a bank of level-sensitive interrupt request lines into one request to a processor. Each line passes through a two-stage synchronizer. A latched copy of the line changes only when the synchronized input changes: a rising edge sets the copy and a falling edge clears it. A per-line enable vector masks the latched copies. The output request is high whenever at least one latched line is also enabled.

Software reaches the block over a simple bus of valid, write, address and data signals, with a 4 KB register window. Two offsets can be read: the count of lines that are both latched and enabled, and the mask of those lines. Three offsets can be written: one clears everything, one masks the lines whose bits are set in the data, and one unmasks them.

The count is kept incrementally as a register. It always equals the population count of the active mask, even when input edges and register writes land in the same clock cycle.

Top module: `irq_level_agg`

## Requirements
- R1: A read (bus_valid high, bus_write low) at offset 0x00 returns, in the low bits of bus_rdata, the number of lines that are both latched high and enabled. The upper bits are zero.
- R2: A read at offset 0x04 returns the bitwise AND of the latched-level vector and the enable vector. Bit n corresponds to line n.
- R3: A write of any value to offset 0x08 clears the enable vector, the latched levels and the count to zero at the next clock edge. If an input edge is detected in that same cycle, it is discarded.
- R4: A write to offset 0x0C clears the enable bits that are set in bus_wdata. The count drops by one for each newly masked line that was latched high.
- R5: A write to offset 0x10 sets the enable bits that are set in bus_wdata. The count rises by one for each newly enabled line that is latched high.
- R6: A rising change on irq_lines[n] sets latched bit n at the third rising clock edge after the change. This latency comes from two synchronizer stages plus edge detection.
- R7: A falling change on irq_lines[n] clears latched bit n with the same latency as R6.
- R8: irq_out is high exactly when the AND of the latched levels and the enables is nonzero.
- R9: A line held high through a write to offset 0x08 is not latched again until it falls and then rises.
- R10: A read at any offset other than 0x00 or 0x04 returns zero, and bus_rdata is zero when no read is presented. A write to any offset other than 0x08, 0x0C or 0x10 leaves all state unchanged.
- R11: The count equals the population count of (level AND enable) after every clock cycle. This holds when input edges and mask or unmask writes occur in the same cycle.
- R12: While rst_n is low, the latched levels, the enables and the count are zero and irq_out is low. Reset is asserted asynchronously and released on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Asynchronous interrupt request lines, one per bit |
| bus_valid | input | 1 | Bus access valid this cycle |
| bus_write | input | 1 | High for a write, low for a read |
| bus_addr | input | 12 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| irq_out | output | 1 | Aggregated interrupt request to the processor |

## Verification
The tests start with directed patterns. Lines are raised while masked, so the latched levels are shown to exist apart from the enables. Lines are then unmasked, masked and lowered one group at a time, which separates the count arithmetic of R4, R5 and R7. A clear-all write while lines stay high, followed by a low-high toggle on one line, distinguishes level tracking from edge tracking (R9). A long stretch of random line patterns follows, with random mask, unmask and clear writes landing in the same cycles as edges. It alternates count and mask reads so that a count that drifts from the mask shows up (R11).

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned OFS_COUNT   = 'h00;
  localparam int unsigned OFS_ACTIVE  = 'h04;
  localparam int unsigned OFS_CLR_ALL = 'h08;
  localparam int unsigned OFS_MASK    = 'h0C;
  localparam int unsigned OFS_UNMASK  = 'h10;

  typedef struct packed {
    logic clr_all;
    logic mask;
    logic unmask;
  } wr_strobe_t;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  logic [LINES-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    rise = sync_q & ~prev_q;
    fall = prev_q & ~sync_q;
  end
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LINES  = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  active,
  input  logic [CNT_W-1:0]  count,
  output wr_strobe_t        strobe,
  output logic [DATA_W-1:0] rdata
);
  logic wr_req, rd_req;

  always_comb begin
    wr_req = bus_valid & bus_write;
    rd_req = bus_valid & ~bus_write;
    strobe.clr_all = wr_req & (bus_addr == ADDR_W'(OFS_CLR_ALL));
    strobe.mask    = wr_req & (bus_addr == ADDR_W'(OFS_MASK));
    strobe.unmask  = wr_req & (bus_addr == ADDR_W'(OFS_UNMASK));
    rdata = '0;
    if (rd_req) begin
      if (bus_addr == ADDR_W'(OFS_COUNT))
        rdata[CNT_W-1:0] = count;
      else if (bus_addr == ADDR_W'(OFS_ACTIVE))
        rdata[LINES-1:0] = active;
    end
  end
endmodule

// File: rtl/irq_pending_core.sv
module irq_pending_core
  import irq_agg_pkg::*;
#(
  parameter int unsigned LINES = 32,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] rise,
  input  logic [LINES-1:0] fall,
  input  wr_strobe_t       strobe,
  input  logic [LINES-1:0] wbits,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] enable,
  output logic [CNT_W-1:0] count,
  output logic [LINES-1:0] active
);
  logic [LINES-1:0] level_d, enable_d, active_d, gained, lost;
  logic [CNT_W-1:0] count_d, n_gain, n_loss;
  logic             level_ce, enable_ce, count_ce;

  always_comb begin
    active = level & enable;
    level_ce  = strobe.clr_all | (|(rise | fall));
    enable_ce = strobe.clr_all | strobe.mask | strobe.unmask;
    count_ce  = level_ce | enable_ce;

    if (strobe.clr_all) level_d = '0;
    else                level_d = (level | rise) & ~fall;

    if (strobe.clr_all)     enable_d = '0;
    else if (strobe.mask)   enable_d = enable & ~wbits;
    else if (strobe.unmask) enable_d = enable | wbits;
    else                    enable_d = enable;

    active_d = level_d & enable_d;
    gained   = active_d & ~active;
    lost     = active & ~active_d;
    n_gain   = '0;
    n_loss   = '0;
    for (int i = 0; i < LINES; i++) begin
      n_gain = n_gain + CNT_W'(gained[i]);
      n_loss = n_loss + CNT_W'(lost[i]);
    end
    if (strobe.clr_all) count_d = '0;
    else                count_d = count + n_gain - n_loss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= '0;
      enable <= '0;
      count  <= '0;
    end else begin
      if (level_ce)  level  <= level_d;
      if (enable_ce) enable <= enable_d;
      if (count_ce)  count  <= count_d;
    end
  end
endmodule

// File: rtl/irq_level_agg.sv
module irq_level_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned LINES  = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_lines,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int unsigned CNT_W = $clog2(LINES + 1);

  logic [1:0]       rst_pipe_q;
  logic             rst_core_n;
  logic [LINES-1:0] rise, fall, level_q, enable_q, active;
  logic [CNT_W-1:0] count_q;
  wr_strobe_t       strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  irq_line_sync #(.LINES(LINES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .din(irq_lines), .rise(rise), .fall(fall)
  );

  irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .CNT_W(CNT_W)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .active(active), .count(count_q), .strobe(strobe), .rdata(bus_rdata)
  );

  irq_pending_core #(.LINES(LINES), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_core_n), .rise(rise), .fall(fall), .strobe(strobe),
    .wbits(bus_wdata[LINES-1:0]), .level(level_q), .enable(enable_q),
    .count(count_q), .active(active)
  );

  assign irq_out = |active;
endmodule

// File: rtl/irq_level_agg_check.sv
module irq_level_agg_check #(
  parameter int unsigned LINES  = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [LINES-1:0]  level_q,
  input logic [LINES-1:0]  enable_q,
  input logic [CNT_W-1:0]  count_q,
  input logic              irq_out
);
  logic wr_clr, wr_msk, wr_unm;
  assign wr_clr = bus_valid && bus_write && bus_addr == ADDR_W'('h08);
  assign wr_msk = bus_valid && bus_write && bus_addr == ADDR_W'('h0C);
  assign wr_unm = bus_valid && bus_write && bus_addr == ADDR_W'('h10);

  AST_OUT_TRACKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_out == ((level_q & enable_q) != '0));                              // R8
  AST_COUNT_IS_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_core_n)
    count_q == CNT_W'($countones(level_q & enable_q)));                   // R11
  AST_CLEAR_ALL_WIPES: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_clr |=> (level_q == '0 && enable_q == '0 && count_q == '0));       // R3
  AST_MASK_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_msk |=> ((enable_q & $past(bus_wdata[LINES-1:0])) == '0));         // R4
  AST_UNMASK_SETS_BITS: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_unm |=> ((enable_q & $past(bus_wdata[LINES-1:0])) == $past(bus_wdata[LINES-1:0]))); // R5
  AST_ENABLE_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(wr_clr || wr_msk || wr_unm) |=> $stable(enable_q));                 // R10
endmodule

bind irq_level_agg irq_level_agg_check #(
  .LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_check (
  .clk(clk), .rst_core_n(rst_core_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .level_q(level_q),
  .enable_q(enable_q), .count_q(count_q), .irq_out(irq_out)
);

// File: tb/irq_level_agg_test.sv
module irq_level_agg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_lines;
  logic        bus_valid, bus_write;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int vectors = 0;
  int errors  = 0;

  // reference state: input history (oldest last), latched levels, enables
  logic [31:0] hist [$];
  bit   [31:0] m_lvl, m_en;

  irq_level_agg uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      bit [31:0] cur, old, up, dn;
      cur = hist[1];
      old = hist[2];
      up = cur & ~old;
      dn = old & ~cur;
      if (bus_valid && bus_write && bus_addr == 12'h008) begin
        m_lvl = '0;
        m_en  = '0;
      end else begin
        m_lvl = (m_lvl | up) & ~dn;
        if (bus_valid && bus_write && bus_addr == 12'h00C) m_en = m_en & ~bus_wdata;
        if (bus_valid && bus_write && bus_addr == 12'h010) m_en = m_en | bus_wdata;
      end
      hist.push_front(irq_lines);
      void'(hist.pop_back());
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [11:0] a,
                      input logic [31:0] d, input logic [31:0] ln, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; irq_lines = ln;
    #1;
    check("R8", {31'b0, irq_out}, {31'b0, (m_lvl & m_en) != 0});
    exp = '0;
    if (v && !w) begin
      if (a == 12'h000) exp = $countones(m_lvl & m_en);
      else if (a == 12'h004) exp = m_lvl & m_en;
    end
    check(tag, bus_rdata, exp);
  endtask

  task automatic rd_cnt(input logic [31:0] ln, input string tag);
    step(1, 0, 12'h000, 32'h0, ln, tag);
  endtask
  task automatic rd_act(input logic [31:0] ln, input string tag);
    step(1, 0, 12'h004, 32'h0, ln, tag);
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [31:0] ln, input string tag);
    step(1, 1, a, d, ln, tag);
  endtask
  task automatic settle(input logic [31:0] ln, input string tag);
    for (int i = 0; i < 2; i++) begin
      rd_cnt(ln, tag);
      rd_act(ln, tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] ln;
    for (int i = 0; i < 3; i++) hist.push_back('0);
    m_lvl = '0; m_en = '0;
    rst_n = 1'b0; irq_lines = '0; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    bus_valid = 1; bus_addr = 12'h004; #1;
    check("R12", {31'b0, irq_out}, 32'h0);
    check("R12", bus_rdata, 32'h0);
    bus_addr = 12'h000; #1;
    check("R12", bus_rdata, 32'h0);
    bus_valid = 0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) rd_cnt(32'h0, "R12");

    // R6: lines latch while masked, nothing active yet
    ln = 32'h0000_00F5;
    settle(ln, "R6");
    // R5: unmask a subset, then the rest
    wr(12'h010, 32'h0000_0005, ln, "R5");
    rd_cnt(ln, "R5");
    rd_act(ln, "R2");
    wr(12'h010, 32'hFFFF_0000, ln, "R5");
    rd_cnt(ln, "R1");
    wr(12'h010, 32'hFFFF_FFFF, ln, "R5");
    rd_cnt(ln, "R1");
    // R4: mask one latched line
    wr(12'h00C, 32'h0000_0004, ln, "R4");
    rd_cnt(ln, "R4");
    rd_act(ln, "R4");
    // R7: drop line 0; R6: raise line 31
    ln = 32'h8000_00F4;
    settle(ln, "R7");
    rd_act(ln, "R6");
    // R10: undefined reads and ignored writes
    step(1, 0, 12'h014, 32'h0, ln, "R10");
    step(1, 0, 12'h800, 32'h0, ln, "R10");
    step(0, 0, 12'h000, 32'h0, ln, "R10");
    wr(12'h014, 32'hFFFF_FFFF, ln, "R10");
    wr(12'h000, 32'h0000_0000, ln, "R10");
    wr(12'h004, 32'hFFFF_FFFF, ln, "R10");
    wr(12'h808, 32'hFFFF_FFFF, ln, "R10");
    rd_cnt(ln, "R10");
    rd_act(ln, "R10");
    // R3: clear all while lines stay high
    wr(12'h008, 32'h1234_5678, ln, "R3");
    rd_cnt(ln, "R3");
    rd_act(ln, "R3");
    // R9: unmask all, held-high lines stay unlatched
    wr(12'h010, 32'hFFFF_FFFF, ln, "R9");
    settle(ln, "R9");
    ln = 32'h8000_00E4;
    settle(ln, "R9");
    ln = 32'h8000_00F4;
    settle(ln, "R9");

    // R11: random edges colliding with writes
    for (int i = 0; i < 1500; i++) begin
      int op;
      if ($urandom_range(3) == 0) ln = ln ^ $urandom();
      op = $urandom_range(39);
      if (op < 6)       wr(12'h010, $urandom(), ln, "R11");
      else if (op < 12) wr(12'h00C, $urandom(), ln, "R11");
      else if (op == 12) wr(12'h008, 32'h0, ln, "R11");
      else if (op < 26) rd_cnt(ln, "R11");
      else              rd_act(ln, "R11");
    end
    settle(ln, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule